// File: doc/BRIEF.md
# Uncorrectable First-Error Logger

This block keeps the uncorrectable error state for a PCI Express style advanced error reporting function. Each of its error inputs is a one-cycle strobe for one error class, and each comes with the header of the packet that raised it. A strobe sets its own bit in a 32-bit status register. Software clears a status bit by writing a 1 to it.

Alongside the status register the block records which error came first and the header of the packet that raised it. When the logger is armed and an error arrives, it stores the bit index of that error as a 5-bit pointer and stores the 128-bit header. It then disarms. Later errors still set status bits, but they leave the pointer and the header alone. The logger arms again only when software clears the status bit that the pointer names. Arming again does not change the stored pointer.

Software reaches everything through a small dword-addressed read/write port. Read data is registered. The control dword reports the pointer and shows all end-to-end CRC capability and enable bits as zero. There are two resets. A cold reset clears all state. A warm reset keeps the status register, the pointer, the header and the armed state.

Top module: `aer_first_err_log`

## Requirements
- R1: Dword address 0 holds the status register. When `err_i[k]` strobes, status bit k is set on the next clock edge. A write to address 0 clears every status bit whose write data bit is 1 and leaves the other bits unchanged. If a strobe and a clearing write hit the same bit in the same cycle, the bit stays set.
- R2: Dword address 1 is the control dword, and bits 4:0 hold the first-error pointer. Bits 31:5 always read 0, including the end-to-end CRC check-enable, check-capable, generate-enable and generate-capable bits. A write to address 1 changes nothing.
- R3: When the logger is armed and one or more strobes are asserted, the logger takes the lowest-numbered asserted bit. At the next edge it stores that bit index as the pointer and that bit's header as the log, and the logger disarms.
- R4: While the logger is disarmed, new strobes set their status bits but do not change the pointer or the header log.
- R5: Clearing any status bit other than the one the pointer names does not arm the logger.
- R6: Clearing the status bit that the pointer names arms the logger. The pointer reads back unchanged until the next capture.
- R7: Suppose a write clears the pointed status bit in the same cycle that new strobes arrive. Those strobes are captured at that edge, as if the logger had already been armed.
- R8: The header log reads as four dwords at addresses 2 to 5. Address 2 holds header bits 31:0, address 3 holds bits 63:32, and so on. Writes to these addresses change nothing. Addresses 6 and 7 read 0.
- R9: A cold reset (`rst_ni` low) clears the status register, the pointer, the header log and the read data, and leaves the logger armed. A warm reset (`warm_rst_ni` low) clears only the read data. Status, pointer, header and armed state are kept.
- R10: The read data after a clock edge is the content of the register at `reg_addr_i`, as it stood just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous; clears all state |
| warm_rst_ni | input | 1 | Warm reset, active low, asynchronous; clears only read data |
| err_i | input | NUM_ERR | One strobe per uncorrectable error class |
| err_hdr_i | input | NUM_ERR*HDR_W | Packet header for each strobe; bit k's header at [k*HDR_W +: HDR_W] |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Dword address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |

## Verification
The bench builds the block with its default sizes: 32 error classes, a 128-bit header and a 3-bit dword address. With these sizes the pointer can reach bit 31, all four header dwords and both unmapped addresses can be read, and errors can collide across the full status width. Directed sequences cover the following cases:
- capture of simultaneous strobes;
- errors that arrive while the logger is locked;
- clears of bits other than the pointed one;
- a clear that coincides with a new error;
- a warm reset in the middle of a run, and a cold reset in the middle of a run.

A long stretch of random strobes and clears then follows. Each header value encodes its bit index, so a wrongly selected header shows up in the dword readback.

// File: rtl/aer_log_pkg.sv
package aer_log_pkg;
  localparam int REG_W       = 32;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int ADDR_HDR0   = 2;
  localparam int PTR_FIELD_W = 5;  // pointer field width in the control dword
endpackage

// File: rtl/aer_status_reg.sv
module aer_status_reg #(
  parameter int NUM_ERR = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_i,
  input  logic [NUM_ERR-1:0] clr_i,
  output logic [NUM_ERR-1:0] status_o
);
  logic [NUM_ERR-1:0] status_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | err_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/aer_lowest_pick.sv
module aer_lowest_pick #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N:0]   below;
  logic [N-1:0] first_hot;

  assign below[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign first_hot[i] = req_i[i] & ~below[i];
    assign below[i+1]   = below[i] | req_i[i];
  end

  assign any_o = below[N];

  always_comb begin
    logic [IDX_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (first_hot[i]) acc = acc | IDX_W'(i);
    end
    idx_o = acc;
  end
endmodule

// File: rtl/aer_hdr_log.sv
module aer_hdr_log #(
  parameter int NUM_ERR = 32,
  parameter int HDR_W   = 128,
  localparam int PTR_W  = $clog2(NUM_ERR)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_ERR-1:0]       err_i,
  input  logic [NUM_ERR*HDR_W-1:0] err_hdr_i,
  input  logic [NUM_ERR-1:0]       clr_i,
  output logic [PTR_W-1:0]         ptr_o,
  output logic [HDR_W-1:0]         hdr_o,
  output logic                     armed_o
);
  logic             any_err;
  logic [PTR_W-1:0] pick_idx;
  logic [HDR_W-1:0] pick_hdr;
  logic [PTR_W-1:0] ptr_q;
  logic [HDR_W-1:0] hdr_q;
  logic             armed_q;
  logic             rearm;
  logic             capture;

  aer_lowest_pick #(.N(NUM_ERR)) u_pick (
    .req_i (err_i),
    .any_o (any_err),
    .idx_o (pick_idx)
  );

  assign pick_hdr = err_hdr_i[pick_idx*HDR_W +: HDR_W];

  // clearing the pointed bit opens the logger in the same cycle
  assign rearm   = ~armed_q & clr_i[ptr_q];
  assign capture = (armed_q | rearm) & any_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      hdr_q   <= '0;
      armed_q <= 1'b1;
    end else if (capture) begin
      ptr_q   <= pick_idx;
      hdr_q   <= pick_hdr;
      armed_q <= 1'b0;
    end else if (rearm) begin
      armed_q <= 1'b1;
    end
  end

  assign ptr_o   = ptr_q;
  assign hdr_o   = hdr_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/aer_first_err_log.sv
module aer_first_err_log
  import aer_log_pkg::*;
#(
  parameter int NUM_ERR = 32,
  parameter int HDR_W   = 128,
  parameter int ADDR_W  = 3,
  localparam int PTR_W  = $clog2(NUM_ERR),
  localparam int HDR_DW = HDR_W / REG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     warm_rst_ni,
  input  logic [NUM_ERR-1:0]       err_i,
  input  logic [NUM_ERR*HDR_W-1:0] err_hdr_i,
  input  logic                     reg_we_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o
);
  logic [NUM_ERR-1:0] status_q;
  logic [NUM_ERR-1:0] clr_mask;
  logic [PTR_W-1:0]   ptr_q;
  logic [HDR_W-1:0]   hdr_q;
  logic               armed_q;
  logic [REG_W-1:0]   ctrl_word;
  logic [REG_W-1:0]   rd_mux;
  logic               rd_rst_n;

  assign clr_mask = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_STATUS))
                    ? reg_wdata_i[NUM_ERR-1:0] : '0;

  aer_status_reg #(.NUM_ERR(NUM_ERR)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err_i),
    .clr_i    (clr_mask),
    .status_o (status_q)
  );

  aer_hdr_log #(.NUM_ERR(NUM_ERR), .HDR_W(HDR_W)) u_log (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .err_i     (err_i),
    .err_hdr_i (err_hdr_i),
    .clr_i     (clr_mask),
    .ptr_o     (ptr_q),
    .hdr_o     (hdr_q),
    .armed_o   (armed_q)
  );

  // CRC capability/enable bits and reserved bits are constant zero
  always_comb begin
    ctrl_word = '0;
    ctrl_word[PTR_W-1:0] = ptr_q;
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == ADDR_W'(ADDR_STATUS)) rd_mux[NUM_ERR-1:0] = status_q;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL))   rd_mux = ctrl_word;
    for (int d = 0; d < HDR_DW; d++) begin
      if (reg_addr_i == ADDR_W'(ADDR_HDR0 + d)) rd_mux = hdr_q[d*REG_W +: REG_W];
    end
  end

  assign rd_rst_n = rst_ni & warm_rst_ni;

  always_ff @(posedge clk_i or negedge rd_rst_n) begin
    if (!rd_rst_n) reg_rdata_o <= '0;
    else           reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/aer_first_err_log_chk.sv
module aer_first_err_log_chk #(
  parameter int NUM_ERR = 32,
  parameter int HDR_W   = 128,
  parameter int ADDR_W  = 3,
  localparam int PTR_W  = $clog2(NUM_ERR)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_ERR-1:0] err_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic [31:0]        reg_rdata_o,
  input logic [NUM_ERR-1:0] status_q,
  input logic [PTR_W-1:0]   ptr_q,
  input logic [HDR_W-1:0]   hdr_q,
  input logic               armed_q
);
  logic clr_ptr;
  assign clr_ptr = reg_we_i && (reg_addr_i == '0) && reg_wdata_i[ptr_q];

  p_err_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(err_i)) == $past(err_i)));

  p_ctrl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(1)) |=> (reg_rdata_o[31:5] == '0));

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (err_i != '0)) |=> (!armed_q && status_q[ptr_q]
                                    && ((($past(err_i) >> ptr_q) & 1) != 0)));

  p_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !clr_ptr) |=> (!armed_q && $stable(ptr_q) && $stable(hdr_q)));

  p_rearm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && clr_ptr && (err_i == '0)) |=> (armed_q && $stable(ptr_q)));
endmodule

bind aer_first_err_log aer_first_err_log_chk #(
  .NUM_ERR (NUM_ERR),
  .HDR_W   (HDR_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .err_i       (err_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .status_q    (status_q),
  .ptr_q       (ptr_q),
  .hdr_q       (hdr_q),
  .armed_q     (armed_q)
);

// File: tb/aer_first_err_log_tb.sv
`timescale 1ns/1ps
module aer_first_err_log_tb;
  localparam int NE = 32;
  localparam int HW = 128;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            warm_rst_ni = 1'b1;
  logic [NE-1:0]   err_i = '0;
  logic [NE*HW-1:0] err_hdr_i;
  logic            reg_we_i = 1'b0;
  logic [2:0]      reg_addr_i = '0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;

  int n_vec = 0;
  int n_bad = 0;
  int hseed = 0;
  bit done = 0;

  bit [31:0]  m_status;
  int         m_ptr;
  bit [127:0] m_hdr;
  bit         m_armed;

  always #2.5 clk_i = ~clk_i;

  aer_first_err_log u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_ni (warm_rst_ni),
    .err_i       (err_i),
    .err_hdr_i   (err_hdr_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o)
  );

  function automatic bit [127:0] hdr_of(int idx, int seed);
    bit [127:0] h;
    for (int d = 0; d < 4; d++)
      h[d*32 +: 32] = 32'h1000_0000 * (d + 1) + (idx << 12) + seed;
    return h;
  endfunction

  always_comb begin
    for (int i = 0; i < NE; i++) err_hdr_i[i*HW +: HW] = hdr_of(i, hseed);
  end

  function automatic bit [31:0] model_rd(int addr);
    if (addr == 0) return m_status;
    if (addr == 1) return 32'(m_ptr);
    if (addr >= 2 && addr <= 5) return m_hdr[(addr-2)*32 +: 32];
    return 32'h0;
  endfunction

  function automatic void model_reset();
    m_status = '0; m_ptr = 0; m_hdr = '0; m_armed = 1'b1;
  endfunction

  function automatic void model_step(bit [31:0] err, bit we, int addr, bit [31:0] wd);
    bit [31:0] clr;
    bit rearm;
    clr   = (we && addr == 0) ? wd : 32'h0;
    rearm = !m_armed && clr[m_ptr];
    if ((m_armed || rearm) && err != 0) begin
      for (int i = NE - 1; i >= 0; i--) if (err[i]) m_ptr = i;
      m_hdr   = hdr_of(m_ptr, hseed);
      m_armed = 1'b0;
    end else if (rearm) begin
      m_armed = 1'b1;
    end
    m_status = (m_status & ~clr) | err;
  endfunction

  task automatic check(string tag, bit [31:0] exp);
    n_vec++;
    if (reg_rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %0d rdata=%h expected %h", tag, reg_addr_i, reg_rdata_o, exp);
    end
  endtask

  task automatic step(string tag, bit [31:0] err, bit we, int addr, bit [31:0] wd);
    bit [31:0] exp;
    err_i = err; reg_we_i = we; reg_addr_i = 3'(addr); reg_wdata_i = wd;
    @(posedge clk_i);
    exp = warm_rst_ni ? model_rd(addr) : 32'h0;
    model_step(err, we, addr, wd);
    @(negedge clk_i);
    err_i = '0; reg_we_i = 1'b0;
    check(tag, exp);
  endtask

  task automatic rd(string tag, int addr);
    step(tag, 32'h0, 1'b0, addr, 32'h0);
  endtask

  task automatic cold_reset();
    rst_ni = 1'b0; err_i = '0; reg_we_i = 1'b0;
    model_reset();
    #1 check("R9 cold", 32'h0);
    @(negedge clk_i);
    check("R9 cold", 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic read_all(string tag);
    for (int a = 0; a < 8; a++) rd(tag, a);
  endtask

  initial begin
    @(negedge clk_i);
    cold_reset();
    read_all("R9 R8 R10 reset state");

    // writes to control and header dwords have no effect
    step("R2 ctrl write", 32'h0, 1'b1, 1, 32'hFFFF_FFFF);
    rd("R2 ctrl readback", 1);
    for (int a = 2; a < 6; a++) step("R8 hdr write", 32'h0, 1'b1, a, 32'hFFFF_FFFF);
    for (int a = 2; a < 6; a++) rd("R8 hdr readback", a);

    // simultaneous errors: lowest wins
    hseed = 7;
    step("R3 capture", (32'h1 << 5) | (32'h1 << 9), 1'b0, 1, 32'h0);
    rd("R3 ptr", 1);
    rd("R1 status", 0);
    for (int a = 2; a < 6; a++) rd("R8 hdr dword", a);

    // locked: later errors only set status
    hseed = 8;
    step("R4 locked err", 32'h1 << 2, 1'b0, 1, 32'h0);
    rd("R4 ptr frozen", 1);
    rd("R4 hdr frozen", 2);
    rd("R1 status bit2", 0);

    // clearing a non-pointed bit keeps the lock
    step("R5 clear other", 32'h0, 1'b1, 0, 32'h1 << 9);
    step("R5 err after", 32'h1 << 0, 1'b0, 1, 32'h0);
    rd("R5 ptr still", 1);
    rd("R5 hdr still", 3);
    rd("R1 status", 0);

    // writing zeros clears nothing
    step("R1 write zero", 32'h0, 1'b1, 0, 32'h0);
    rd("R1 status kept", 0);

    // clearing pointed bit re-arms, pointer unchanged
    step("R6 clear ptr bit", 32'h0, 1'b1, 0, 32'h1 << 5);
    rd("R6 ptr unchanged", 1);
    hseed = 3;
    step("R6 next capture", 32'h1 << 31, 1'b0, 1, 32'h0);
    rd("R6 new ptr", 1);
    rd("R6 new hdr", 5);

    // clear pointed bit together with new error
    hseed = 11;
    step("R7 clear+err", 32'h1 << 12, 1'b1, 0, 32'h1 << 31);
    rd("R7 ptr", 1);
    rd("R7 hdr", 4);

    // set and clear of the same bit in one cycle: set wins
    step("R1 set wins", 32'h1 << 20, 1'b1, 0, 32'h1 << 20);
    rd("R1 status", 0);

    // warm reset: read data zero, sticky state kept
    warm_rst_ni = 1'b0;
    rd("R9 warm rdata", 1);
    rd("R9 warm rdata", 0);
    warm_rst_ni = 1'b1;
    read_all("R9 after warm");

    // address sweep, one-cycle read latency
    for (int a = 7; a >= 0; a--) rd("R10 sweep", a);

    // cold reset mid-run, then capture from armed
    cold_reset();
    read_all("R9 cold mid");
    hseed = 21;
    step("R9 armed after cold", 32'h1 << 17, 1'b0, 1, 32'h0);
    rd("R9 ptr", 1);
    rd("R9 hdr", 2);

    // random mix of strobes, clears and reads
    for (int n = 0; n < 2000; n++) begin
      bit [31:0] e;
      bit [31:0] w;
      int a;
      hseed = int'($urandom_range(0, 255));
      e = ($urandom_range(0, 3) == 0) ? ((32'h1 << $urandom_range(0, 31)) |
          (($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0)) : 32'h0;
      a = int'($urandom_range(0, 7));
      w = ($urandom_range(0, 1) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      step("R3 R4 R6 R7 random", e, $urandom_range(0, 3) == 0, a, w);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule